// File: doc/BRIEF.md
# Per-Sector ECC Status Collector

This block sits behind the ECC decoder of a page-oriented flash controller. For every page read, the decoder delivers one corrected-error count per 512-byte sector, in sector order. The collector packs those counts into 32-bit status words and keeps a running sum of the corrected errors. When a sector is reported as uncorrectable, the collector marks the page as failing only if the page does not read as erased.

To decide whether the page is erased, the collector reads the page buffer back one word per cycle. It scans every main-area word and the spare-area words that hold ECC bytes. It ignores the free spare bytes, which software may have written. A new page read is announced with a one-cycle `start` pulse. `done` then stays high with stable results until the next `start`.

Top module: `ecc_status_collector`

## Requirements
- R1: While `rst_n` is low at a clock edge, the block clears its state. After reset, `done`, `page_uncorr`, `corr_total` and every status word read zero.
- R2: The 4-bit count of sector n is placed in status word n/4, at bits (3 - n mod 4)*8 +: 4, so lower sectors occupy higher-order bytes. The upper four bits of each byte lane read zero.
- R3: A count of 15 marks the sector as uncorrectable. `corr_total` is the sum of the counts of the sectors received before the first uncorrectable one. Counts after that sector are still packed but are not added.
- R4: If no sector is uncorrectable, `done` rises on the cycle after the last sector is accepted, with `page_uncorr` low. The block issues no buffer read.
- R5: If a sector is uncorrectable and the page is not blank, `page_uncorr` is high when `done` rises. The buffer layout is as follows. Word address = byte offset / 4, with 32-bit words. The main area covers bytes 0 to PAGE_BYTES-1. The spare area starts at byte PAGE_BYTES. The ECC bytes start at spare offset 8, with 8 bytes per sector (or 16 when ECC_STRONG=1). The page is blank when every main word is 0xFFFFFFFF and every ECC byte is 0xFF.
- R6: If a sector is uncorrectable and the page is blank, `page_uncorr` stays low when `done` rises.
- R7: Spare bytes outside the ECC byte positions have no effect on the blank decision.
- R8: The blank scan issues one read per cycle, and `buf_rd_data` is expected one cycle after `buf_rd_en`. It addresses only main words and ECC words. It stops issuing reads once a non-blank word has been returned. A page whose first word is not blank therefore costs two reads, and a blank page costs one read per scanned word.
- R9: `start` clears the status words, `corr_total`, `page_uncorr` and `done`, even in the middle of a page, and begins a new collection from sector 0.
- R10: `sec_valid` is ignored unless a collection is in progress.
- R11: Once `done` is high, it and all results stay unchanged until the next `start`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | New page read begins; clears results |
| sec_valid | input | 1 | A sector result is present on `sec_count` |
| sec_count | input | 4 | Corrected-error count of the sector, 15 = uncorrectable |
| buf_rd_en | output | 1 | Page buffer read request |
| buf_rd_addr | output | AW (10) | Page buffer word address |
| buf_rd_data | input | 32 | Buffer word, valid one cycle after the request |
| done | output | 1 | Results final for this page |
| page_uncorr | output | 1 | Page has an uncorrectable sector and is not blank |
| corr_total | output | TOT_W (6) | Sum of corrected errors before the first uncorrectable sector |
| stat_words | output | NUM_WORDS*32 (32) | Packed per-sector counts, word 0 in the low bits |

## Verification
Several properties are checked on every cycle:
- `done` and the results hold steady until `start`.
- `start` clears everything.
- The corrected total never decreases within a page.
- `page_uncorr` is only ever seen with `done`.
- Buffer reads never fall in the two spare words before the ECC bytes, and never occur once `done` is high.

Other behaviours only the bench's scenarios can show:
- The lane placement of each count.
- The total stopping at the first uncorrectable sector.
- Blank-page suppression for each possible location of a dirty word.
- The free spare bytes being ignored.
- The exact number of reads in a full scan and in an early-stopped scan.

// File: rtl/ecc_stat_pkg.sv
// Package: shared constants and the control state type of the ECC status
// collector. Assumes 32-bit buffer words and 4-bit per-sector counts.
package ecc_stat_pkg;
    localparam int WORD_W       = 32;
    localparam int LANE_W       = 8;
    localparam int CNT_W        = 4;
    localparam int SECTOR_BYTES = 512;
    localparam int ECC_OFS_W    = 2;   // spare word holding the first ECC byte
    localparam logic [CNT_W-1:0] UNCORR_CODE = 4'hF;

    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_COLLECT = 2'd1,
        ST_SCAN    = 2'd2,
        ST_DONE    = 2'd3
    } ctl_state_e;
endpackage

// File: rtl/ecc_sector_packer.sv
// Module: ecc_sector_packer
// Holds one count per sector in its byte lane of the status words, tracks the
// sector index and accumulates corrected errors until the first count of 15.
// Assumes sectors arrive in order 0..N-1 and the caller gates `accept`.
module ecc_sector_packer
    import ecc_stat_pkg::*;
#(
    parameter int N_SECT    = 4,
    parameter int NUM_WORDS = 1,
    parameter int TOT_W     = 6
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        clear,
    input  logic                        accept,
    input  logic [CNT_W-1:0]            count,
    output logic                        last_o,
    output logic                        uncorr_o,
    output logic [TOT_W-1:0]            total_o,
    output logic [NUM_WORDS*WORD_W-1:0] words_o
);
    localparam int SIDX_W = (N_SECT > 1) ? $clog2(N_SECT) : 1;
    localparam int LANES  = NUM_WORDS * (WORD_W / LANE_W);

    logic [SIDX_W-1:0] idx_q;
    logic              halted_q;
    logic [TOT_W-1:0]  total_q;
    logic [CNT_W-1:0]  cnt_q [N_SECT];

    // Sector index: next sector to be received
    always_ff @(posedge clk) begin
        if (!rst_n || clear)
            idx_q <= '0;
        else if (accept && !last_o)
            idx_q <= idx_q + 1'b1;
    end

    // Running total and stop-on-uncorrectable flag
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            halted_q <= 1'b0;
            total_q  <= '0;
        end else if (accept && !halted_q) begin
            if (count == UNCORR_CODE)
                halted_q <= 1'b1;
            else
                total_q <= total_q + TOT_W'(count);
        end
    end

    genvar s;
    generate
        for (s = 0; s < LANES; s++) begin : g_lane
            localparam int W_IDX = s / 4;
            localparam int LSB   = W_IDX * WORD_W + (3 - (s % 4)) * LANE_W;
            if (s < N_SECT) begin : g_used
                // Capture this sector's count when its turn comes
                always_ff @(posedge clk) begin
                    if (!rst_n || clear)
                        cnt_q[s] <= '0;
                    else if (accept && idx_q == SIDX_W'(s))
                        cnt_q[s] <= count;
                end
                assign words_o[LSB +: LANE_W] = {{(LANE_W-CNT_W){1'b0}}, cnt_q[s]};
            end else begin : g_unused
                assign words_o[LSB +: LANE_W] = '0;
            end
        end
    endgenerate

    assign last_o   = (idx_q == SIDX_W'(N_SECT - 1));
    assign uncorr_o = halted_q;
    assign total_o  = total_q;
endmodule

// File: rtl/ecc_blank_scanner.sv
// Module: ecc_blank_scanner
// Reads the page buffer one word per cycle over the main area and then the
// ECC words of the spare area, and reports whether all of them are all ones.
// Assumes read data returns one cycle after the request; stops early on the
// first non-blank word. `abort` cancels a scan in progress.
module ecc_blank_scanner
    import ecc_stat_pkg::*;
#(
    parameter int MAIN_WORDS = 512,
    parameter int ECC_WORDS  = 8,
    parameter int AW         = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              go,
    input  logic              abort,
    output logic              rd_en,
    output logic [AW-1:0]     rd_addr,
    input  logic [WORD_W-1:0] rd_data,
    output logic              done_o,
    output logic              blank_o
);
    localparam int SCAN_WORDS = MAIN_WORDS + ECC_WORDS;
    localparam int KW         = $clog2(SCAN_WORDS + 1);

    logic          issue_q;
    logic [KW-1:0] k_q;
    logic          pend_q;
    logic          pend_last_q;
    logic          bad_word;

    assign bad_word = pend_q && (rd_data != '1);

    // Issue pointer: one read per cycle until the last word or a failure
    always_ff @(posedge clk) begin
        if (!rst_n || abort) begin
            issue_q <= 1'b0;
            k_q     <= '0;
        end else if (go) begin
            issue_q <= 1'b1;
            k_q     <= '0;
        end else if (bad_word) begin
            issue_q <= 1'b0;
        end else if (issue_q) begin
            k_q <= k_q + 1'b1;
            if (k_q == KW'(SCAN_WORDS - 1))
                issue_q <= 1'b0;
        end
    end

    // Track the read in flight and whether it is the final one
    always_ff @(posedge clk) begin
        if (!rst_n || abort || bad_word) begin
            pend_q      <= 1'b0;
            pend_last_q <= 1'b0;
        end else begin
            pend_q      <= issue_q;
            pend_last_q <= issue_q && (k_q == KW'(SCAN_WORDS - 1));
        end
    end

    // Result pulse with the blank verdict
    always_ff @(posedge clk) begin
        if (!rst_n || abort) begin
            done_o  <= 1'b0;
            blank_o <= 1'b0;
        end else begin
            done_o  <= bad_word || (pend_q && pend_last_q);
            blank_o <= !bad_word;
        end
    end

    // Skip the two spare words that precede the ECC bytes
    always_comb begin
        if (k_q < KW'(MAIN_WORDS))
            rd_addr = AW'(k_q);
        else
            rd_addr = AW'(k_q) + AW'(ECC_OFS_W);
    end

    assign rd_en = issue_q;
endmodule

// File: rtl/ecc_status_collector.sv
// Module: ecc_status_collector (top)
// Collects per-sector ECC counts of one page read into packed status words and
// a corrected total; on an uncorrectable sector it scans the page buffer and
// flags the page only when it is not blank. Assumes one sector result per
// sec_valid, in order, after a start pulse.
module ecc_status_collector
    import ecc_stat_pkg::*;
#(
    parameter int PAGE_BYTES  = 2048,
    parameter int SPARE_BYTES = 64,
    parameter int ECC_STRONG  = 0,
    localparam int N_SECT     = PAGE_BYTES / SECTOR_BYTES,
    localparam int NUM_WORDS  = (N_SECT + 3) / 4,
    localparam int TOT_W      = $clog2(N_SECT * 14 + 1),
    localparam int AW         = $clog2((PAGE_BYTES + SPARE_BYTES) / 4)
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        start,
    input  logic                        sec_valid,
    input  logic [3:0]                  sec_count,
    output logic                        buf_rd_en,
    output logic [AW-1:0]               buf_rd_addr,
    input  logic [31:0]                 buf_rd_data,
    output logic                        done,
    output logic                        page_uncorr,
    output logic [TOT_W-1:0]            corr_total,
    output logic [NUM_WORDS*32-1:0]     stat_words
);
    localparam int MAIN_WORDS = PAGE_BYTES / 4;
    localparam int ECC_BPS    = (ECC_STRONG != 0) ? 16 : 8;
    localparam int ECC_WORDS  = (N_SECT * ECC_BPS) / 4;

    ctl_state_e state_q;
    logic       accept;
    logic       last_sect;
    logic       uncorr_seen;
    logic       need_scan;
    logic       scan_go;
    logic       scan_done;
    logic       scan_blank;
    logic       flag_q;

    assign accept    = sec_valid && (state_q == ST_COLLECT) && !start;
    assign need_scan = uncorr_seen || (sec_count == UNCORR_CODE);
    assign scan_go   = accept && last_sect && need_scan;

    ecc_sector_packer #(
        .N_SECT   (N_SECT),
        .NUM_WORDS(NUM_WORDS),
        .TOT_W    (TOT_W)
    ) u_pack (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear   (start),
        .accept  (accept),
        .count   (sec_count),
        .last_o  (last_sect),
        .uncorr_o(uncorr_seen),
        .total_o (corr_total),
        .words_o (stat_words)
    );

    ecc_blank_scanner #(
        .MAIN_WORDS(MAIN_WORDS),
        .ECC_WORDS (ECC_WORDS),
        .AW        (AW)
    ) u_scan (
        .clk    (clk),
        .rst_n  (rst_n),
        .go     (scan_go),
        .abort  (start),
        .rd_en  (buf_rd_en),
        .rd_addr(buf_rd_addr),
        .rd_data(buf_rd_data),
        .done_o (scan_done),
        .blank_o(scan_blank)
    );

    // Page-level control: collect, optionally scan, then hold results
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else if (start) begin
            state_q <= ST_COLLECT;
        end else begin
            case (state_q)
                ST_COLLECT: if (accept && last_sect)
                                state_q <= need_scan ? ST_SCAN : ST_DONE;
                ST_SCAN:    if (scan_done)
                                state_q <= ST_DONE;
                default:    state_q <= state_q;
            endcase
        end
    end

    // Page failure flag: set only by a non-blank scan result
    always_ff @(posedge clk) begin
        if (!rst_n || start)
            flag_q <= 1'b0;
        else if (state_q == ST_SCAN && scan_done)
            flag_q <= !scan_blank;
    end

    assign done        = (state_q == ST_DONE);
    assign page_uncorr = flag_q;
endmodule

// File: rtl/ecc_status_collector_chk.sv
// Module: ecc_status_collector_chk
// Checker bound to the collector top: cycle-level properties on its ports.
module ecc_status_collector_chk #(
    parameter int AW         = 10,
    parameter int TOT_W      = 6,
    parameter int SW         = 32,
    parameter int MAIN_WORDS = 512,
    parameter int ECC_WORDS  = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             start,
    input logic             buf_rd_en,
    input logic [AW-1:0]    buf_rd_addr,
    input logic             done,
    input logic             page_uncorr,
    input logic [TOT_W-1:0] corr_total,
    input logic [SW-1:0]    stat_words
);
    p_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> (stat_words == '0 && corr_total == '0 && !done && !page_uncorr));

    p_done_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !start) |=> (done && $stable(stat_words) && $stable(corr_total)
                              && $stable(page_uncorr)));

    p_total_mono_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !start |=> (corr_total >= $past(corr_total)));

    p_flag_needs_done_r5: assert property (@(posedge clk) disable iff (!rst_n)
        page_uncorr |-> done);

    p_no_read_when_done_r4: assert property (@(posedge clk) disable iff (!rst_n)
        buf_rd_en |-> !done);

    p_addr_window_r8: assert property (@(posedge clk) disable iff (!rst_n)
        buf_rd_en |-> ((buf_rd_addr < AW'(MAIN_WORDS)) ||
                       (buf_rd_addr >= AW'(MAIN_WORDS + 2) &&
                        buf_rd_addr <  AW'(MAIN_WORDS + 2 + ECC_WORDS))));
endmodule

bind ecc_status_collector ecc_status_collector_chk #(
    .AW        (AW),
    .TOT_W     (TOT_W),
    .SW        (NUM_WORDS * 32),
    .MAIN_WORDS(MAIN_WORDS),
    .ECC_WORDS (ECC_WORDS)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (start),
    .buf_rd_en  (buf_rd_en),
    .buf_rd_addr(buf_rd_addr),
    .done       (done),
    .page_uncorr(page_uncorr),
    .corr_total (corr_total),
    .stat_words (stat_words)
);

// File: tb/sim_ecc_status_collector.sv
module sim_ecc_status_collector;
    localparam int MAINW  = 512;
    localparam int TOTW   = 528;
    localparam int SCANW  = 520;   // 512 main + 8 ECC words
    localparam int ECC_LO = MAINW + 2;
    localparam int ECC_HI = MAINW + 9;

    // vector: {c0,c1,c2,c3} counts, then 3-bit buffer pattern
    // patterns: 0 blank, 1 first main word dirty, 2 last main word dirty,
    //           3 last ECC word dirty, 4 only free spare bytes dirty
    localparam logic [18:0] VEC [9] = '{
        {4'd1,  4'd2,  4'd3,  4'd4,  3'd0},
        {4'd0,  4'd0,  4'd0,  4'd0,  3'd1},
        {4'd3,  4'd15, 4'd5,  4'd2,  3'd1},
        {4'd3,  4'd15, 4'd5,  4'd2,  3'd0},
        {4'd15, 4'd0,  4'd0,  4'd0,  3'd3},
        {4'd2,  4'd15, 4'd15, 4'd1,  3'd4},
        {4'd14, 4'd14, 4'd14, 4'd14, 3'd0},
        {4'd0,  4'd0,  4'd7,  4'd15, 3'd2},
        {4'd9,  4'd6,  4'd15, 4'd3,  3'd3}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic        sec_valid = 1'b0;
    logic [3:0]  sec_count = '0;
    logic        buf_rd_en;
    logic [9:0]  buf_rd_addr;
    logic [31:0] buf_rd_data = '0;
    logic        done;
    logic        page_uncorr;
    logic [5:0]  corr_total;
    logic [31:0] stat_words;

    logic [31:0] mem [TOTW];
    int          rd_cnt = 0;
    int          n_chk = 0;
    int          n_err = 0;
    int          cyc = 0;

    always #2 clk = ~clk;

    ecc_status_collector u0 (
        .clk(clk), .rst_n(rst_n), .start(start), .sec_valid(sec_valid),
        .sec_count(sec_count), .buf_rd_en(buf_rd_en), .buf_rd_addr(buf_rd_addr),
        .buf_rd_data(buf_rd_data), .done(done), .page_uncorr(page_uncorr),
        .corr_total(corr_total), .stat_words(stat_words)
    );

    // buffer model: one-cycle read latency, plus read counter
    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (buf_rd_en) begin
            buf_rd_data <= mem[buf_rd_addr];
            rd_cnt      <= rd_cnt + 1;
        end
    end

    always @(negedge clk) begin
        if (cyc > 150000) begin
            n_err = n_err + 1;
            $display("FAIL watchdog: run hung (actual %0d cycles, expected < 150000)", cyc);
            $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
            $finish;
        end
    end

    task automatic chk(input bit ok, input string req, input logic [63:0] act,
                       input logic [63:0] exp);
        n_chk = n_chk + 1;
        if (!ok) begin
            n_err = n_err + 1;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic fill(input int pat);
        for (int i = 0; i < TOTW; i++) mem[i] = 32'hFFFF_FFFF;
        case (pat)
            1: mem[0]      = 32'hFFFF_FFFE;
            2: mem[MAINW-1] = 32'h7FFF_FFFF;
            3: mem[ECC_HI] = 32'hFFFF_00FF;
            4: begin
                mem[MAINW]     = 32'h00FF_FFFF;   // spare offset 0..3
                mem[MAINW + 1] = 32'h1234_5678;   // spare offset 4..7
                mem[ECC_HI + 1] = 32'h0000_0000;  // spare offset 40..43
            end
            default: ;
        endcase
    endtask

    task automatic pulse_start();
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic send(input logic [3:0] c);
        sec_valid = 1'b1;
        sec_count = c;
        @(negedge clk);
        sec_valid = 1'b0;
    endtask

    task automatic wait_done();
        for (int i = 0; i < 2000 && !done; i++) @(negedge clk);
    endtask

    initial begin
        logic [3:0]  c [4];
        logic [31:0] exp_w;
        int          exp_t;
        bit          any_u;
        bit          exp_f;
        int          r0;
        int          pat;

        fill(0);
        repeat (3) @(negedge clk);
        // R1: reset state
        chk(done == 0 && page_uncorr == 0, "R1 flags", {done, page_uncorr}, 0);
        chk(stat_words == 0 && corr_total == 0, "R1 results", {stat_words, corr_total}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        // R10: sector result before any start is ignored
        send(4'd5);
        @(negedge clk);
        chk(stat_words == 0 && corr_total == 0 && !done, "R10 idle ignore",
            {stat_words, corr_total}, 0);

        // table walk
        for (int v = 0; v < 9; v++) begin
            pat = int'(VEC[v][2:0]);
            fill(pat);
            exp_w = '0; exp_t = 0; any_u = 0;
            for (int s = 0; s < 4; s++) begin
                c[s] = VEC[v][18 - 4*s -: 4];
                exp_w[(3 - s)*8 +: 8] = {4'h0, c[s]};
                if (!any_u) begin
                    if (c[s] == 4'd15) any_u = 1;
                    else exp_t = exp_t + int'(c[s]);
                end
            end
            exp_f = any_u && (pat >= 1 && pat <= 3);
            pulse_start();
            r0 = rd_cnt;
            for (int s = 0; s < 4; s++) begin
                send(c[s]);
                if (v % 2 == 1 && s < 3) @(negedge clk);   // gap between sectors
            end
            if (!any_u) begin
                // R4: done the cycle after the last sector, no reads
                chk(done == 1, "R4 done timing", done, 1);
                chk(rd_cnt == r0, "R4 no reads", rd_cnt - r0, 0);
            end
            wait_done();
            chk(stat_words == exp_w, "R2 packing", stat_words, exp_w);
            chk(corr_total == exp_t, "R3 total", corr_total, exp_t);
            if (exp_f)
                chk(page_uncorr == 1, "R5 not blank", page_uncorr, 1);
            else if (any_u && pat == 4)
                chk(page_uncorr == 0, "R7 free spare ignored", page_uncorr, 0);
            else
                chk(page_uncorr == 0, "R6 blank suppress", page_uncorr, 0);
            if (any_u && pat == 0)
                chk(rd_cnt - r0 == SCANW, "R8 full scan", rd_cnt - r0, SCANW);
            if (any_u && pat == 1)
                chk(rd_cnt - r0 == 2, "R8 early stop", rd_cnt - r0, 2);
        end

        // R11: results held, and R10: late sector ignored
        exp_w = stat_words;
        send(4'd9);
        repeat (10) @(negedge clk);
        chk(done == 1 && stat_words == exp_w, "R11 hold / R10 ignore after done",
            stat_words, exp_w);

        // R9: restart in the middle of a page
        pulse_start();
        send(4'd4);
        send(4'd6);
        pulse_start();
        chk(stat_words == 0 && corr_total == 0 && !done, "R9 restart clears",
            {stat_words, corr_total}, 0);
        send(4'd1); send(4'd1); send(4'd1); send(4'd2);
        chk(done == 1 && corr_total == 5 && stat_words == 32'h0101_0102,
            "R9 fresh page", {corr_total, stat_words}, {6'd5, 32'h0101_0102});

        // R9: start during a scan aborts it
        fill(0);
        pulse_start();
        send(4'd15); send(4'd0); send(4'd0); send(4'd0);
        repeat (5) @(negedge clk);
        pulse_start();
        r0 = rd_cnt;
        repeat (3) @(negedge clk);
        chk(rd_cnt == r0 && !done && !page_uncorr, "R9 abort scan", rd_cnt - r0, 0);

        // R1: reset mid-page
        send(4'd3);
        rst_n = 1'b0;
        @(negedge clk);
        chk(stat_words == 0 && corr_total == 0 && !done, "R1 reset mid-page",
            {stat_words, corr_total}, 0);

        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end
endmodule